// File: doc/BRIEF.md
# Intermittent Cycle-Steal DMA Sequencer

This block is one DMA channel that moves data between two memory regions by stealing bus tenures from another bus master. Software-side logic loads a source address, a destination address, a unit count, a unit size and a spacing mode, then pulses a start input. Each unit is moved as a read from the source and a write of the same data to the destination. A unit moves only while an active-low, level-sensitive transfer request input is held low. For every unit the block asks an arbiter for the bus, moves exactly one unit, and then drops its request again.

The spacing mode sets how soon the bus may be requested again after a release. In normal mode the block may ask again on the next cycle. In the two intermittent modes it stays off the bus for at least 16 or 64 bus clocks, which limits the share of bus bandwidth the channel takes. A done flag reports that the count has run out.

Top module: `sdma_seq`

## Requirements
- R1: While reset is high, and in the cycle after it, bus_req_o, mem_rd_o, mem_wr_o and done_o are all low.
- R2: A start pulse is accepted only while the channel is idle. It loads the configuration and clears done_o (for a nonzero count). A start pulse that arrives while a transfer is in progress has no effect on addresses, count or mode.
- R3: A new bus request is raised only in the cycle after xfer_req_n_i was sampled low. While xfer_req_n_i stays high, bus_req_o stays low.
- R4: mem_rd_o and mem_wr_o are asserted only while bus_gnt_i is high. bus_req_o stays high while the grant is withheld.
- R5: Each beat reads the source address and then, in the next granted cycle, writes the data just read to the destination address. Read and write are never asserted together.
- R6: unit_i encodes the unit size: 0 = byte, 1 = 16-bit, 2 = 32-bit, 3 = 16 bytes. mem_size_o carries codes 0/1/2. A 16-byte unit is four 32-bit beats at offsets 0, 4, 8 and 12 within one tenure, with mem_size_o = 2.
- R7: After each completed unit, the source and destination addresses each advance by the unit size in bytes (1, 2, 4 or 16), and the remaining count falls by one.
- R8: bus_req_o falls in the cycle after the last write of every unit, so exactly one unit is moved per tenure.
- R9: gap_mode_i = 0 (normal). With the request held low, bus_req_o is low for exactly one cycle between units.
- R10: gap_mode_i = 1 gives a gap of at least 16 cycles, and 2 or 3 gives at least 64 cycles, counted from the cycle after release. With the request held low, the gap is exactly 16 or 64 cycles.
- R11: done_o rises in the cycle after the last write of the final unit and stays high until the next accepted start. A start with count 0 sets done_o in the next cycle with no bus activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Arm pulse, loads configuration |
| src_i | input | AW | Source start address |
| dst_i | input | AW | Destination start address |
| count_i | input | CW | Number of units to move |
| unit_i | input | 2 | Unit size code (R6) |
| gap_mode_i | input | 2 | 0 normal, 1 gap 16, 2/3 gap 64 |
| xfer_req_n_i | input | 1 | Active-low level transfer request |
| bus_req_o | output | 1 | Bus request to arbiter |
| bus_gnt_i | input | 1 | Bus grant from arbiter |
| mem_addr_o | output | AW | Bus address |
| mem_size_o | output | 2 | Access width code (0 byte, 1 16-bit, 2 32-bit) |
| mem_rd_o | output | 1 | Read strobe, data returned same cycle |
| mem_wr_o | output | 1 | Write strobe |
| mem_wdata_o | output | DW | Write data |
| mem_rdata_i | input | DW | Read data |
| done_o | output | 1 | Count exhausted flag |

## Verification
The timing rules are as follows. A request sampled low raises bus_req_o one cycle later. A grant seen at an edge starts the read on the next cycle, and the matching write follows one cycle after that read. The release and done_o both appear one cycle after the final write. The gap lengths are counted in the cycles where bus_req_o is low between a fall and the next rise. A behavioural model in the bench advances on each rising edge from the same inputs. It is compared with the outputs one nanosecond before the next edge, after every input change of that cycle has settled. Each scenario also checks write totals, last addresses and measured gap lengths against figures derived directly from the requirements.

// File: rtl/sdma_pkg.sv
package sdma_pkg;

    typedef enum logic [1:0] {
        UNIT_B = 2'd0,
        UNIT_H = 2'd1,
        UNIT_L = 2'd2,
        UNIT_Q = 2'd3
    } unit_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_REQ,
        ST_RD,
        ST_WR,
        ST_GAP
    } st_e;

    typedef struct packed {
        unit_e      unit;
        logic [1:0] mode;
    } xfer_cfg_t;

    function automatic logic [4:0] unit_bytes(unit_e u);
        case (u)
            UNIT_B:  return 5'd1;
            UNIT_H:  return 5'd2;
            UNIT_L:  return 5'd4;
            default: return 5'd16;
        endcase
    endfunction

    function automatic logic [1:0] beat_last(unit_e u);
        return (u == UNIT_Q) ? 2'd3 : 2'd0;
    endfunction

    function automatic logic [1:0] beat_size(unit_e u);
        return (u == UNIT_Q) ? 2'd2 : 2'(u);
    endfunction

endpackage

// File: rtl/sdma_gap_timer.sv
module sdma_gap_timer #(
    parameter int GW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic [GW-1:0] len_i,
    output logic          expired_o
);
    logic [GW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= len_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q <= GW'(1));
endmodule

// File: rtl/sdma_addr_unit.sv
module sdma_addr_unit
    import sdma_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic [AW-1:0] src_i,
    input  logic [AW-1:0] dst_i,
    input  logic [CW-1:0] cnt_i,
    input  unit_e         unit_i,
    input  logic          advance_i,
    input  logic          beat_inc_i,
    output logic [AW-1:0] rd_addr_o,
    output logic [AW-1:0] wr_addr_o,
    output logic          last_beat_o,
    output logic          last_unit_o
);
    logic [AW-1:0] src_q, dst_q;
    logic [CW-1:0] cnt_q;
    logic [1:0]    beat_q;
    logic [AW-1:0] step;
    logic [AW-1:0] offs;

    assign step = AW'(unit_bytes(unit_i));
    assign offs = AW'(beat_q) << 2;

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q  <= '0;
            dst_q  <= '0;
            cnt_q  <= '0;
            beat_q <= '0;
        end else if (load_i) begin
            src_q  <= src_i;
            dst_q  <= dst_i;
            cnt_q  <= cnt_i;
            beat_q <= '0;
        end else if (advance_i) begin
            src_q  <= src_q + step;
            dst_q  <= dst_q + step;
            cnt_q  <= cnt_q - 1'b1;
            beat_q <= '0;
        end else if (beat_inc_i) begin
            beat_q <= beat_q + 1'b1;
        end
    end

    assign rd_addr_o   = src_q + offs;
    assign wr_addr_o   = dst_q + offs;
    assign last_beat_o = (beat_q == beat_last(unit_i));
    assign last_unit_o = (cnt_q == CW'(1));
endmodule

// File: rtl/sdma_fsm.sv
module sdma_fsm
    import sdma_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic count_zero_i,
    input  logic req_n_i,
    input  logic gnt_i,
    input  logic last_beat_i,
    input  logic last_unit_i,
    input  logic spaced_i,
    input  logic gap_expired_i,
    output logic load_o,
    output logic advance_o,
    output logic beat_inc_o,
    output logic cap_o,
    output logic gap_load_o,
    output logic bus_req_o,
    output logic rd_o,
    output logic wr_o,
    output logic done_o
);
    st_e  st_q, st_n;
    logic done_q, done_n;

    always_comb begin
        st_n       = st_q;
        done_n     = done_q;
        load_o     = 1'b0;
        advance_o  = 1'b0;
        beat_inc_o = 1'b0;
        cap_o      = 1'b0;
        gap_load_o = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (start_i) begin
                    load_o = 1'b1;
                    if (count_zero_i) begin
                        done_n = 1'b1;
                    end else begin
                        done_n = 1'b0;
                        st_n   = ST_ARM;
                    end
                end
            end
            ST_ARM: begin
                if (!req_n_i) st_n = ST_REQ;
            end
            ST_REQ: begin
                if (gnt_i) st_n = ST_RD;
            end
            ST_RD: begin
                if (gnt_i) begin
                    cap_o = 1'b1;
                    st_n  = ST_WR;
                end
            end
            ST_WR: begin
                if (gnt_i) begin
                    if (last_beat_i) begin
                        advance_o = 1'b1;
                        if (last_unit_i) begin
                            done_n = 1'b1;
                            st_n   = ST_IDLE;
                        end else if (spaced_i) begin
                            gap_load_o = 1'b1;
                            st_n       = ST_GAP;
                        end else begin
                            st_n = ST_ARM;
                        end
                    end else begin
                        beat_inc_o = 1'b1;
                        st_n       = ST_RD;
                    end
                end
            end
            ST_GAP: begin
                if (gap_expired_i) st_n = ST_ARM;
            end
            default: st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b0;
        end else begin
            st_q   <= st_n;
            done_q <= done_n;
        end
    end

    assign bus_req_o = (st_q == ST_REQ) || (st_q == ST_RD) || (st_q == ST_WR);
    assign rd_o      = (st_q == ST_RD) && gnt_i;
    assign wr_o      = (st_q == ST_WR) && gnt_i;
    assign done_o    = done_q;
endmodule

// File: rtl/sdma_seq.sv
module sdma_seq
    import sdma_pkg::*;
#(
    parameter int AW        = 32,
    parameter int CW        = 16,
    parameter int DW        = 32,
    parameter int GAP_SHORT = 16,
    parameter int GAP_LONG  = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic [AW-1:0] src_i,
    input  logic [AW-1:0] dst_i,
    input  logic [CW-1:0] count_i,
    input  logic [1:0]    unit_i,
    input  logic [1:0]    gap_mode_i,
    input  logic          xfer_req_n_i,
    output logic          bus_req_o,
    input  logic          bus_gnt_i,
    output logic [AW-1:0] mem_addr_o,
    output logic [1:0]    mem_size_o,
    output logic          mem_rd_o,
    output logic          mem_wr_o,
    output logic [DW-1:0] mem_wdata_o,
    input  logic [DW-1:0] mem_rdata_i,
    output logic          done_o
);
    localparam int GW = $clog2(GAP_LONG + 1);

    xfer_cfg_t     cfg_q;
    logic [DW-1:0] data_q;
    logic [1:0]    gap_sel;
    logic [GW-1:0] gap_len;
    logic          load, advance, beat_inc, data_cap, gap_load, gap_expired;
    logic          last_beat, last_unit;
    logic [AW-1:0] rd_addr, wr_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '{unit: UNIT_B, mode: 2'd0};
        end else if (load) begin
            cfg_q <= '{unit: unit_e'(unit_i), mode: gap_mode_i};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
        end else if (data_cap) begin
            data_q <= mem_rdata_i;
        end
    end

    assign gap_sel = cfg_q.mode;
    assign gap_len = gap_sel[1] ? GW'(GAP_LONG - 1) : GW'(GAP_SHORT - 1);

    sdma_fsm u_fsm (
        .clk           (clk),
        .rst           (rst),
        .start_i       (start_i),
        .count_zero_i  (count_i == '0),
        .req_n_i       (xfer_req_n_i),
        .gnt_i         (bus_gnt_i),
        .last_beat_i   (last_beat),
        .last_unit_i   (last_unit),
        .spaced_i      (gap_sel != 2'd0),
        .gap_expired_i (gap_expired),
        .load_o        (load),
        .advance_o     (advance),
        .beat_inc_o    (beat_inc),
        .cap_o         (data_cap),
        .gap_load_o    (gap_load),
        .bus_req_o     (bus_req_o),
        .rd_o          (mem_rd_o),
        .wr_o          (mem_wr_o),
        .done_o        (done_o)
    );

    sdma_addr_unit #(.AW(AW), .CW(CW)) u_addr (
        .clk         (clk),
        .rst         (rst),
        .load_i      (load),
        .src_i       (src_i),
        .dst_i       (dst_i),
        .cnt_i       (count_i),
        .unit_i      (cfg_q.unit),
        .advance_i   (advance),
        .beat_inc_i  (beat_inc),
        .rd_addr_o   (rd_addr),
        .wr_addr_o   (wr_addr),
        .last_beat_o (last_beat),
        .last_unit_o (last_unit)
    );

    sdma_gap_timer #(.GW(GW)) u_gap (
        .clk       (clk),
        .rst       (rst),
        .load_i    (gap_load),
        .len_i     (gap_len),
        .expired_o (gap_expired)
    );

    assign mem_addr_o  = mem_wr_o ? wr_addr : rd_addr;
    assign mem_size_o  = beat_size(cfg_q.unit);
    assign mem_wdata_o = data_q;
endmodule

// File: rtl/sdma_seq_chk.sv
module sdma_seq_chk #(
    parameter int GAP_SHORT = 16,
    parameter int GAP_LONG  = 64
) (
    input logic       clk,
    input logic       rst,
    input logic       xfer_req_n_i,
    input logic       bus_req_o,
    input logic       bus_gnt_i,
    input logic       mem_rd_o,
    input logic       mem_wr_o,
    input logic       done_o,
    input logic       load_i,
    input logic [1:0] mode_i
);
    localparam int LW = $clog2(GAP_LONG + 1) + 1;

    logic [LW-1:0] low_run;
    logic          req_prev, gap_live;
    logic [LW-1:0] need;

    assign need = mode_i[1] ? LW'(GAP_LONG) : LW'(GAP_SHORT);

    always_ff @(posedge clk) begin
        if (rst) begin
            low_run  <= '0;
            req_prev <= 1'b0;
            gap_live <= 1'b0;
        end else begin
            req_prev <= bus_req_o;
            if (bus_req_o) low_run <= '0;
            else if (low_run != '1) low_run <= low_run + 1'b1;
            if (load_i) gap_live <= 1'b0;
            else if (req_prev && !bus_req_o) gap_live <= 1'b1;
        end
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!bus_req_o && !mem_rd_o && !mem_wr_o && !done_o));

    a_r3_level_req: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_req_o) |-> $past(!xfer_req_n_i));

    a_r4_rd_granted: assert property (@(posedge clk) disable iff (rst)
        mem_rd_o |-> (bus_gnt_i && bus_req_o));

    a_r4_wr_granted: assert property (@(posedge clk) disable iff (rst)
        mem_wr_o |-> (bus_gnt_i && bus_req_o));

    a_r5_no_overlap: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd_o && mem_wr_o));

    a_r10_min_gap: assert property (@(posedge clk) disable iff (rst)
        (bus_req_o && !req_prev && gap_live && mode_i != 2'd0) |-> (low_run >= need));

    a_r11_done_sticky: assert property (@(posedge clk) disable iff (rst)
        (done_o && !load_i) |=> done_o);
endmodule

bind sdma_seq sdma_seq_chk #(.GAP_SHORT(GAP_SHORT), .GAP_LONG(GAP_LONG)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .xfer_req_n_i (xfer_req_n_i),
    .bus_req_o    (bus_req_o),
    .bus_gnt_i    (bus_gnt_i),
    .mem_rd_o     (mem_rd_o),
    .mem_wr_o     (mem_wr_o),
    .done_o       (done_o),
    .load_i       (load),
    .mode_i       (gap_sel)
);

// File: tb/sdma_seq_bench.sv
module sdma_seq_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [31:0] src_i = '0, dst_i = '0;
    logic [15:0] count_i = '0;
    logic [1:0]  unit_i = '0, gap_mode_i = '0;
    logic        xfer_req_n_i = 1'b1;
    logic        bus_req_o, bus_gnt_i = 1'b0;
    logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
    logic [1:0]  mem_size_o;
    logic        mem_rd_o, mem_wr_o, done_o;
    logic        allow = 1'b1;

    int tests = 0, fails = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    function automatic logic [31:0] rdf(logic [31:0] a);
        return {a[15:0] ^ 16'h5A3C, a[15:0]};
    endfunction

    assign mem_rdata_i = rdf(mem_addr_o);

    always @(negedge clk) bus_gnt_i <= bus_req_o && allow;

    sdma_seq u_sdma_seq (
        .clk(clk), .rst(rst), .start_i(start_i), .src_i(src_i), .dst_i(dst_i),
        .count_i(count_i), .unit_i(unit_i), .gap_mode_i(gap_mode_i),
        .xfer_req_n_i(xfer_req_n_i), .bus_req_o(bus_req_o), .bus_gnt_i(bus_gnt_i),
        .mem_addr_o(mem_addr_o), .mem_size_o(mem_size_o), .mem_rd_o(mem_rd_o),
        .mem_wr_o(mem_wr_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
        .done_o(done_o)
    );

    task automatic chk(bit ok, string rq, string what, longint act, longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", rq, what, act, exp, $time);
        end
    endtask

    function automatic int ubytes(int u);
        return (u == 0) ? 1 : (u == 1) ? 2 : (u == 2) ? 4 : 16;
    endfunction

    function automatic int gapn(int md);
        return (md == 0) ? 0 : (md == 1) ? 16 : 64;
    endfunction

    // reference model: phase 0 idle, 1 waiting for request, 2 asking, 3 owning bus, 4 spacing
    int          ph = 0, m_cnt = 0, m_unit = 0, m_mode = 0, m_beat = 0, m_gapleft = 0;
    bit          m_wr = 0, m_done = 0;
    logic [31:0] m_src = '0, m_dst = '0;

    always @(posedge clk) begin
        if (rst) begin
            ph = 0; m_done = 0;
        end else begin
            case (ph)
                0: if (start_i) begin
                    m_src = src_i; m_dst = dst_i; m_cnt = int'(count_i);
                    m_unit = int'(unit_i); m_mode = int'(gap_mode_i);
                    if (m_cnt == 0) m_done = 1;
                    else begin m_done = 0; ph = 1; end
                end
                1: if (!xfer_req_n_i) ph = 2;
                2: if (bus_gnt_i) begin ph = 3; m_beat = 0; m_wr = 0; end
                3: if (bus_gnt_i) begin
                    if (!m_wr) m_wr = 1;
                    else begin
                        m_wr = 0;
                        if (m_beat == ((m_unit == 3) ? 3 : 0)) begin
                            m_src += ubytes(m_unit);
                            m_dst += ubytes(m_unit);
                            m_cnt--;
                            if (m_cnt == 0) begin m_done = 1; ph = 0; end
                            else if (gapn(m_mode) > 0) begin ph = 4; m_gapleft = gapn(m_mode) - 1; end
                            else ph = 1;
                        end else m_beat++;
                    end
                end
                4: begin
                    if (m_gapleft <= 1) ph = 1;
                    m_gapleft--;
                end
                default: ph = 0;
            endcase
        end
    end

    // comparison and monitors, 1 ns before the next rising edge
    int          gaps[$];
    int          low_run = 0, wr_n = 0, rd_n = 0;
    bit          prev_req = 0;
    logic [31:0] last_wr = '0;

    always @(posedge clk) begin
        #7;
        if (!rst) begin
            bit e_req, e_rd, e_wr;
            logic [31:0] off;
            e_req = (ph == 2) || (ph == 3);
            e_rd  = (ph == 3) && !m_wr && bus_gnt_i;
            e_wr  = (ph == 3) && m_wr && bus_gnt_i;
            off   = (m_unit == 3) ? 32'(m_beat * 4) : 32'd0;
            chk(bus_req_o == e_req, "R8", "bus_req", bus_req_o, e_req);
            chk(mem_rd_o == e_rd, "R4", "mem_rd", mem_rd_o, e_rd);
            chk(mem_wr_o == e_wr, "R5", "mem_wr", mem_wr_o, e_wr);
            chk(done_o == m_done, "R11", "done", done_o, m_done);
            if (e_rd) begin
                chk(mem_addr_o == m_src + off, "R7", "rd addr", mem_addr_o, m_src + off);
                chk(int'(mem_size_o) == ((m_unit == 3) ? 2 : m_unit), "R6", "size", mem_size_o, (m_unit == 3) ? 2 : m_unit);
            end
            if (e_wr) begin
                chk(mem_addr_o == m_dst + off, "R7", "wr addr", mem_addr_o, m_dst + off);
                chk(mem_wdata_o == rdf(m_src + off), "R5", "wdata", mem_wdata_o, rdf(m_src + off));
            end
            if (bus_req_o && !prev_req) begin gaps.push_back(low_run); low_run = 0; end
            if (!bus_req_o) low_run++;
            prev_req = bus_req_o;
            if (mem_wr_o) begin wr_n++; last_wr = mem_addr_o; end
            if (mem_rd_o) rd_n++;
        end
    end

    task automatic do_start(logic [31:0] s, logic [31:0] d, int n, int u, int md);
        @(negedge clk);
        start_i = 1; src_i = s; dst_i = d; count_i = 16'(n); unit_i = 2'(u); gap_mode_i = 2'(md);
        @(negedge clk);
        start_i = 0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 5000 && !done_o; i++) @(negedge clk);
    endtask

    task automatic run_xfer(logic [31:0] s, logic [31:0] d, int n, int u, int md, int egap, string rq);
        int beats;
        beats = (u == 3) ? 4 : 1;
        xfer_req_n_i = 0;
        gaps.delete(); wr_n = 0;
        do_start(s, d, n, u, md);
        wait_done();
        chk(done_o == 1, "R11", "done after run", done_o, 1);
        chk(gaps.size() == n, "R8", "tenures", gaps.size(), n);
        for (int i = 1; i < gaps.size(); i++)
            chk(gaps[i] == egap, rq, "gap length", gaps[i], egap);
        chk(wr_n == n * beats, "R6", "write beats", wr_n, n * beats);
        chk(last_wr == d + 32'((n - 1) * ubytes(u) + ((u == 3) ? 12 : 0)), "R7", "last write addr",
            last_wr, d + 32'((n - 1) * ubytes(u) + ((u == 3) ? 12 : 0)));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!bus_req_o && !mem_rd_o && !mem_wr_o && !done_o, "R1", "reset outputs",
            {bus_req_o, mem_rd_o, mem_wr_o, done_o}, 0);
        rst = 0;
        @(negedge clk);
        chk(!bus_req_o && !done_o, "R1", "post reset", {bus_req_o, done_o}, 0);

        // R11: zero count start finishes at once with no bus use
        wr_n = 0; gaps.delete();
        xfer_req_n_i = 0;
        do_start(32'h100, 32'h200, 0, 2, 0);
        chk(done_o == 1, "R11", "zero count done", done_o, 1);
        repeat (10) @(negedge clk);
        chk(gaps.size() == 0 && wr_n == 0, "R11", "zero count bus idle", gaps.size() + wr_n, 0);

        // R9: normal mode, longwords
        run_xfer(32'h1000, 32'h8000, 4, 2, 0, 1, "R9");
        // R10: gap 16, 16-bit units
        run_xfer(32'h2002, 32'h9000, 3, 1, 1, 16, "R10");
        // R10 / R6: gap 64, 16-byte units
        run_xfer(32'h3000, 32'hA000, 2, 3, 2, 64, "R10");
        // R10: mode 3 behaves as 64
        run_xfer(32'h3101, 32'hA101, 2, 0, 3, 64, "R10");
        // R11: done holds
        repeat (10) @(negedge clk);
        chk(done_o == 1, "R11", "done sticky", done_o, 1);

        // R3: request held high blocks the bus
        xfer_req_n_i = 1; gaps.delete(); wr_n = 0;
        do_start(32'h4000, 32'hB000, 2, 2, 0);
        repeat (20) @(negedge clk);
        chk(gaps.size() == 0 && bus_req_o == 0, "R3", "no request while high", gaps.size(), 0);
        xfer_req_n_i = 0;
        wait_done();
        chk(wr_n == 2, "R3", "writes after request", wr_n, 2);

        // R4: grant withheld
        allow = 0; rd_n = 0; wr_n = 0;
        do_start(32'h5000, 32'hC000, 1, 0, 0);
        repeat (12) @(negedge clk);
        chk(bus_req_o == 1, "R4", "req held w/o grant", bus_req_o, 1);
        chk(rd_n == 0, "R4", "no read w/o grant", rd_n, 0);
        allow = 1;
        wait_done();
        chk(wr_n == 1 && last_wr == 32'hC000, "R4", "write after grant", last_wr, 32'hC000);

        // R2: start while busy is ignored
        wr_n = 0; gaps.delete();
        do_start(32'h6000, 32'hD000, 3, 1, 1);
        repeat (25) @(negedge clk);
        do_start(32'h7700, 32'hE700, 9, 2, 0);
        wait_done();
        chk(wr_n == 3, "R2", "busy start count", wr_n, 3);
        chk(last_wr == 32'hD004, "R2", "busy start addr", last_wr, 32'hD004);

        repeat (4) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            tests++; fails++;
            $display("FAIL R11 watchdog: actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule